// File: doc/BRIEF.md
# Punctured Viterbi Block Decoder with CRC-12 Check

This block decodes one protected control block made of hard-decision bits. The block must already be deinterleaved and descrambled. The coded bits arrive one at a time with a qualifier, and a strobe marks the first bit of each block. The encoder is rate 1/2 with constraint length 5, and a fixed pattern deletes some of its outputs. The block puts an erasure back into each deleted position. Erasures cost nothing in the branch metric.

A 16-state add-compare-select array updates the path metrics once for each trellis step. The metrics use Hamming distance, saturate at their ceiling and are normalised every step. The decisions for every step are kept in storage. Once the last step is in, the block traces back from the all-zero state, because the encoder ends on a known zero tail.

The 92 decoded bits then pass serially through a CRC-12 register. The block presents the 80 payload bits together with a pass flag, and marks them with a one-cycle valid pulse.

The control path is one state machine with five states:
- IDLE waits for a strobe.
- LOAD accepts coded bits and steps the trellis. It moves to TRACE after the last step.
- TRACE walks back one step per cycle. It moves to CHECK after step 0.
- CHECK feeds one decoded bit per cycle into the CRC. It moves to DONE after the 92nd bit.
- DONE publishes the result and returns to IDLE.

A qualified strobe in any state goes to LOAD and starts a fresh block. This abandons whatever was in progress.

Top module: `vit_blk_dec`

## Requirements
- R1: The code window is 5 bits wide, with the oldest input in bit 4 and the current input in bit 0. Each coded bit is the parity of the window ANDed with a generator: 5'b10011 for the first output and 5'b11101 for the second. The encoder starts in the all-zero state.
- R2: Trellis steps are numbered from 0. An even step sends only its first-generator bit. An odd step sends its first-generator bit and then its second-generator bit. A block is 144 coded bits, and its first bit has in_start high together with in_valid.
- R3: The decoded sequence has 96 steps: 80 payload bits, then 12 CRC bits, then 4 zero tail bits. The bit of step t (t < 80) appears at out_payload[79-t]. An error-free block reproduces its payload exactly.
- R4: A block with isolated single coded-bit errors, at least 40 coded bits apart, still yields the original payload with out_crc_ok high.
- R5: The CRC register is 12 bits wide and is preset to all ones. It has generator x^12+x^11+x^3+x^2+x+1 (0x80F) and takes the bits MSB first. The 12 CRC bits are the register contents after the 80 payload bits, sent from bit 11 down to bit 0. out_crc_ok is high only when the register is zero after all 92 decoded bits. A wrong CRC field gives out_crc_ok low, with the decoded payload still presented.
- R6: out_valid is high for exactly one cycle per completed block. out_payload and out_crc_ok change only with out_valid and hold their values until the next one.
- R7: A qualified start strobe in the middle of a block abandons the current block. Only the new block produces a result.
- R8: In IDLE, coded bits without a start strobe are ignored. Bits beyond the 144th of a block are ignored. Idle cycles between bits are allowed.
- R9: After reset, out_valid, out_payload and out_crc_ok are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Qualifies in_bit in this cycle |
| in_start | input | 1 | Marks the first bit of a block (used with in_valid) |
| in_bit | input | 1 | Hard-decision coded bit |
| out_valid | output | 1 | One-cycle pulse when a result is published |
| out_payload | output | 80 | Decoded payload, first decoded bit in the MSB |
| out_crc_ok | output | 1 | High when the CRC-12 remainder was zero |

## Verification
The bound checker watches the following on every cycle:
- out_valid is a single-cycle pulse and is issued only from the DONE state.
- The published payload does not move between pulses.
- A qualified strobe always lands the controller in LOAD.
- Unqualified bits never move it out of IDLE.

Only the bench scenarios can show the following, because each needs a full encoded block and a reference encoder:
- The decoded bits are correct.
- Isolated errors are corrected.
- The CRC verdict is right for good and corrupted check fields.
- Aborted blocks leave no trace.
- Surplus bits are ignored.

// File: rtl/vit_pkg.sv
package vit_pkg;
    localparam int VIT_K      = 5;
    localparam int VIT_MEM    = VIT_K - 1;
    localparam int VIT_STATES = 1 << VIT_MEM;
    localparam logic [VIT_K-1:0] VIT_G0 = 5'o23;
    localparam logic [VIT_K-1:0] VIT_G1 = 5'o35;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_TRACE,
        ST_CHECK,
        ST_DONE
    } vit_state_t;

    function automatic logic tap_parity(input logic [VIT_K-1:0] win,
                                        input logic [VIT_K-1:0] gen);
        return ^(win & gen);
    endfunction
endpackage

// File: rtl/vit_depunct.sv
module vit_depunct (
    input  logic clk,
    input  logic rst_n,
    input  logic sof,
    input  logic take,
    input  logic bit_i,
    output logic sym_valid,
    output logic sym_c0,
    output logic sym_c1,
    output logic sym_c1_en
);
    typedef enum logic [1:0] {P_EVEN, P_ODD_A, P_ODD_B} slot_t;
    slot_t slot;
    logic  held;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot      <= P_EVEN;
            held      <= 1'b0;
            sym_valid <= 1'b0;
            sym_c0    <= 1'b0;
            sym_c1    <= 1'b0;
            sym_c1_en <= 1'b0;
        end else begin
            sym_valid <= 1'b0;
            if (take) begin
                if (sof || slot == P_EVEN) begin
                    sym_c0    <= bit_i;
                    sym_c1    <= 1'b0;
                    sym_c1_en <= 1'b0;
                    sym_valid <= 1'b1;
                    slot      <= P_ODD_A;
                end else if (slot == P_ODD_A) begin
                    held <= bit_i;
                    slot <= P_ODD_B;
                end else begin
                    sym_c0    <= held;
                    sym_c1    <= bit_i;
                    sym_c1_en <= 1'b1;
                    sym_valid <= 1'b1;
                    slot      <= P_EVEN;
                end
            end
        end
    end
endmodule

// File: rtl/vit_acs.sv
module vit_acs #(
    parameter int METRIC_W = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic init,
    input  logic step_en,
    input  logic c0,
    input  logic c1,
    input  logic c1_en,
    output logic [vit_pkg::VIT_STATES-1:0] dec
);
    import vit_pkg::*;
    localparam int NS = VIT_STATES;
    localparam logic [METRIC_W-1:0] MMAX     = '1;
    localparam logic [METRIC_W-1:0] INIT_FAR = MMAX >> 1;

    logic [METRIC_W-1:0] metric [NS];
    logic [METRIC_W-1:0] nm     [NS];
    logic [METRIC_W-1:0] mn;

    function automatic logic [METRIC_W-1:0] sat_add(input logic [METRIC_W-1:0] a,
                                                   input logic [1:0] b);
        logic [METRIC_W:0] s;
        s = {1'b0, a} + (METRIC_W+1)'(b);
        return s[METRIC_W] ? MMAX : s[METRIC_W-1:0];
    endfunction

    for (genvar ns = 0; ns < NS; ns++) begin : g_acs
        localparam int P0 = ns >> 1;
        localparam int P1 = (ns >> 1) | (NS >> 1);
        localparam logic [VIT_K-1:0] W0 = VIT_K'((P0 << 1) | (ns & 1));
        localparam logic [VIT_K-1:0] W1 = VIT_K'((P1 << 1) | (ns & 1));
        localparam logic E00 = tap_parity(W0, VIT_G0);
        localparam logic E01 = tap_parity(W0, VIT_G1);
        localparam logic E10 = tap_parity(W1, VIT_G0);
        localparam logic E11 = tap_parity(W1, VIT_G1);
        logic [1:0] bm0, bm1;
        logic [METRIC_W-1:0] cand0, cand1;
        always_comb begin
            bm0   = {1'b0, c0 ^ E00} + {1'b0, c1_en & (c1 ^ E01)};
            bm1   = {1'b0, c0 ^ E10} + {1'b0, c1_en & (c1 ^ E11)};
            cand0 = sat_add(metric[P0], bm0);
            cand1 = sat_add(metric[P1], bm1);
            dec[ns] = (cand1 < cand0);
            nm[ns]  = (cand1 < cand0) ? cand1 : cand0;
        end
    end

    always_comb begin
        mn = nm[0];
        for (int i = 1; i < NS; i++) begin
            if (nm[i] < mn) mn = nm[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NS; i++) metric[i] <= (i == 0) ? '0 : INIT_FAR;
        end else if (init) begin
            for (int i = 0; i < NS; i++) metric[i] <= (i == 0) ? '0 : INIT_FAR;
        end else if (step_en) begin
            for (int i = 0; i < NS; i++) metric[i] <= nm[i] - mn;
        end
    end
endmodule

// File: rtl/vit_crc.sv
module vit_crc #(
    parameter int              CRC_W    = 12,
    parameter logic [CRC_W-1:0] CRC_POLY = 12'h80F
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init,
    input  logic             en,
    input  logic             bit_i,
    output logic [CRC_W-1:0] rem
);
    logic fb;
    assign fb = rem[CRC_W-1] ^ bit_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    rem <= '1;
        else if (init) rem <= '1;
        else if (en)   rem <= {rem[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
    end
endmodule

// File: rtl/vit_blk_dec.sv
module vit_blk_dec #(
    parameter int               PAYLOAD_W = 80,
    parameter int               CRC_W     = 12,
    parameter logic [CRC_W-1:0] CRC_POLY  = 12'h80F,
    parameter int               METRIC_W  = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic                 in_start,
    input  logic                 in_bit,
    output logic                 out_valid,
    output logic [PAYLOAD_W-1:0] out_payload,
    output logic                 out_crc_ok
);
    import vit_pkg::*;
    localparam int N_DEC   = PAYLOAD_W + CRC_W;
    localparam int N_STEPS = N_DEC + VIT_MEM;
    localparam int N_CODED = (N_STEPS * 3) / 2;
    localparam int SW      = $clog2(N_STEPS);
    localparam int DW      = $clog2(N_DEC);
    localparam int BW      = $clog2(N_CODED + 1);

    vit_state_t state, nstate;

    logic sof, take, step_en, last_step;
    logic sym_valid, sym_c0, sym_c1, sym_c1_en;
    logic [VIT_STATES-1:0] acs_dec;
    logic [VIT_STATES-1:0] dec_mem [N_STEPS];
    logic [SW-1:0]      step_cnt, tb_idx;
    logic [VIT_MEM-1:0] tb_state;
    logic [DW-1:0]      crc_idx, tb_pos, crc_pos;
    logic [BW-1:0]      bits_in;
    logic [N_DEC-1:0]   tb_bits;
    logic [CRC_W-1:0]   crc_rem;
    logic crc_init, crc_en;

    assign sof       = in_valid & in_start;
    assign take      = in_valid & (in_start | (state == ST_LOAD && bits_in < BW'(N_CODED)));
    assign step_en   = sym_valid & (state == ST_LOAD) & ~sof;
    assign last_step = (step_cnt == SW'(N_STEPS - 1));
    assign tb_pos    = DW'(N_DEC - 1) - DW'(tb_idx);
    assign crc_pos   = DW'(N_DEC - 1) - crc_idx;
    assign crc_init  = (state == ST_TRACE) && (tb_idx == '0) && !sof;
    assign crc_en    = (state == ST_CHECK) && !sof;

    vit_depunct u_depunct (
        .clk       (clk),
        .rst_n     (rst_n),
        .sof       (sof),
        .take      (take),
        .bit_i     (in_bit),
        .sym_valid (sym_valid),
        .sym_c0    (sym_c0),
        .sym_c1    (sym_c1),
        .sym_c1_en (sym_c1_en)
    );

    vit_acs #(.METRIC_W(METRIC_W)) u_acs (
        .clk     (clk),
        .rst_n   (rst_n),
        .init    (sof),
        .step_en (step_en),
        .c0      (sym_c0),
        .c1      (sym_c1),
        .c1_en   (sym_c1_en),
        .dec     (acs_dec)
    );

    vit_crc #(.CRC_W(CRC_W), .CRC_POLY(CRC_POLY)) u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .init  (crc_init),
        .en    (crc_en),
        .bit_i (tb_bits[crc_pos]),
        .rem   (crc_rem)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nstate;
    end

    always_comb begin
        nstate = state;
        unique case (state)
            ST_IDLE:  if (sof) nstate = ST_LOAD;
            ST_LOAD:  if (!sof && step_en && last_step) nstate = ST_TRACE;
            ST_TRACE: if (sof) nstate = ST_LOAD;
                      else if (tb_idx == '0) nstate = ST_CHECK;
            ST_CHECK: if (sof) nstate = ST_LOAD;
                      else if (crc_idx == DW'(N_DEC - 1)) nstate = ST_DONE;
            ST_DONE:  nstate = sof ? ST_LOAD : ST_IDLE;
            default:  nstate = ST_IDLE;
        endcase
    end

    // survivor storage, no reset needed
    always_ff @(posedge clk) begin
        if (step_en) dec_mem[step_cnt] <= acs_dec;
    end

    // datapath counters and traceback
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bits_in  <= '0;
            step_cnt <= '0;
            tb_idx   <= '0;
            tb_state <= '0;
            crc_idx  <= '0;
            tb_bits  <= '0;
        end else if (sof) begin
            bits_in  <= BW'(1);
            step_cnt <= '0;
        end else begin
            if (take) bits_in <= bits_in + 1'b1;
            if (step_en) begin
                step_cnt <= step_cnt + 1'b1;
                if (last_step) begin
                    tb_idx   <= SW'(N_STEPS - 1);
                    tb_state <= '0;
                end
            end
            if (state == ST_TRACE) begin
                if (tb_idx < SW'(N_DEC)) tb_bits[tb_pos] <= tb_state[0];
                tb_state <= {dec_mem[tb_idx][tb_state], tb_state[VIT_MEM-1:1]};
                if (tb_idx != '0) tb_idx <= tb_idx - 1'b1;
                else              crc_idx <= '0;
            end
            if (crc_en) crc_idx <= crc_idx + 1'b1;
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            out_payload <= '0;
            out_crc_ok  <= 1'b0;
        end else begin
            out_valid <= 1'b0;
            if (state == ST_DONE && !sof) begin
                out_valid   <= 1'b1;
                out_payload <= tb_bits[N_DEC-1 -: PAYLOAD_W];
                out_crc_ok  <= (crc_rem == '0);
            end
        end
    end
endmodule

// File: rtl/vit_blk_dec_chk.sv
module vit_blk_dec_chk #(
    parameter int PAYLOAD_W = 80
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  in_valid,
    input logic                  in_start,
    input logic                  out_valid,
    input logic [PAYLOAD_W-1:0]  out_payload,
    input logic                  out_crc_ok,
    input vit_pkg::vit_state_t   state
);
    import vit_pkg::*;

    assert_valid_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    assert_payload_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> ($stable(out_payload) && $stable(out_crc_ok)));

    assert_valid_from_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(state) == ST_DONE);

    assert_start_restarts_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_start) |=> state == ST_LOAD);

    assert_idle_ignores_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !(in_valid && in_start)) |=> state == ST_IDLE);
endmodule

bind vit_blk_dec vit_blk_dec_chk #(.PAYLOAD_W(PAYLOAD_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_start    (in_start),
    .out_valid   (out_valid),
    .out_payload (out_payload),
    .out_crc_ok  (out_crc_ok),
    .state       (state)
);

// File: tb/tb_vit_blk_dec.sv
module tb_vit_blk_dec;
    localparam int CLK_PERIOD = 10;
    localparam int PW   = 80;
    localparam int NDEC = 92;
    localparam int NST  = 96;
    localparam int NCOD = 144;
    localparam logic [11:0] POLY = 12'h80F;
    localparam logic [4:0]  GA = 5'b10011;
    localparam logic [4:0]  GB = 5'b11101;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic in_start = 1'b0;
    logic in_bit = 1'b0;
    logic out_valid;
    logic [PW-1:0] out_payload;
    logic out_crc_ok;

    int checks = 0;
    int failures = 0;
    int vcnt = 0;
    bit finished = 1'b0;

    logic coded [0:159];
    logic flip  [0:159];

    always #(CLK_PERIOD/2) clk = ~clk;

    vit_blk_dec dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_start    (in_start),
        .in_bit      (in_bit),
        .out_valid   (out_valid),
        .out_payload (out_payload),
        .out_crc_ok  (out_crc_ok)
    );

    always @(negedge clk) if (rst_n && out_valid) vcnt++;

    task automatic chk(input bit ok, input string tag, input logic [PW-1:0] act,
                       input logic [PW-1:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // reference encoder per R1, R2, R3, R5
    task automatic encode(input logic [PW-1:0] pay, input bit bad_crc);
        logic [11:0] r;
        logic d [0:NST-1];
        logic [3:0] s;
        logic [4:0] w;
        int k;
        r = '1;
        for (int i = 0; i < PW; i++) begin
            logic fb;
            fb = r[11] ^ pay[PW-1-i];
            r  = {r[10:0], 1'b0} ^ (fb ? POLY : 12'h000);
        end
        if (bad_crc) r = r ^ 12'h021;
        for (int i = 0; i < NST; i++) begin
            if (i < PW)        d[i] = pay[PW-1-i];
            else if (i < NDEC) d[i] = r[11-(i-PW)];
            else               d[i] = 1'b0;
        end
        s = '0;
        k = 0;
        for (int t = 0; t < NST; t++) begin
            w = {s, d[t]};
            coded[k] = ^(w & GA); k++;
            if (t % 2 == 1) begin
                coded[k] = ^(w & GB); k++;
            end
            s = w[3:0];
        end
        for (int i = NCOD; i < 160; i++) coded[i] = 1'b1;
        for (int i = 0; i < 160; i++) flip[i] = 1'b0;
    endtask

    task automatic send(input int n, input int gap);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_start = (i == 0);
            in_bit   = coded[i] ^ flip[i];
            @(negedge clk);
            in_valid = 1'b0;
            in_start = 1'b0;
            for (int g = 0; g < gap; g++) @(negedge clk);
        end
    endtask

    task automatic wait_result(input logic [PW-1:0] exp_pay, input bit exp_ok,
                               input string tag);
        int base;
        base = vcnt;
        for (int i = 0; i < 600 && vcnt == base; i++) @(negedge clk);
        repeat (4) @(negedge clk);
        chk(vcnt == base + 1, {tag, " R6 one pulse"}, PW'(vcnt - base), PW'(1));
        chk(out_valid == 1'b0, {tag, " R6 pulse width"}, PW'(out_valid), PW'(0));
        chk(out_payload == exp_pay, {tag, " R3 payload"}, out_payload, exp_pay);
        chk(out_crc_ok == exp_ok, {tag, " R5 crc_ok"}, PW'(out_crc_ok), PW'(exp_ok));
    endtask

    task automatic t_reset();
        chk(out_valid == 1'b0, "R9 valid", PW'(out_valid), PW'(0));
        chk(out_payload == '0, "R9 payload", out_payload, '0);
        chk(out_crc_ok == 1'b0, "R9 crc_ok", PW'(out_crc_ok), PW'(0));
    endtask

    task automatic t_clean(input logic [PW-1:0] p, input string tag);
        encode(p, 1'b0);
        send(NCOD, 0);
        wait_result(p, 1'b1, {tag, " R1 R2 clean"});
    endtask

    task automatic t_errors();
        logic [PW-1:0] p = 80'h3C5A_0F96_E1D2_7B48_A6C3;
        encode(p, 1'b0);
        flip[20] = 1'b1;
        flip[70] = 1'b1;
        flip[120] = 1'b1;
        send(NCOD, 0);
        wait_result(p, 1'b1, "R4 corrected");
    endtask

    task automatic t_bad_crc();
        logic [PW-1:0] p = 80'h1234_5678_9ABC_DEF0_1357;
        encode(p, 1'b1);
        send(NCOD, 0);
        wait_result(p, 1'b0, "R5 bad field");
    endtask

    task automatic t_abort();
        logic [PW-1:0] pa = 80'hFFFF_0000_FFFF_0000_FFFF;
        logic [PW-1:0] pb = 80'h0F0F_F0F0_5555_AAAA_C3C3;
        encode(pa, 1'b0);
        send(70, 0);
        encode(pb, 1'b0);
        send(NCOD, 0);
        wait_result(pb, 1'b1, "R7 abort");
    endtask

    task automatic t_ignore();
        logic [PW-1:0] held;
        int base;
        held = out_payload;
        base = vcnt;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_start = 1'b0;
            in_bit   = i[0] ^ i[3];
        end
        @(negedge clk);
        in_valid = 1'b0;
        repeat (400) @(negedge clk);
        chk(vcnt == base, "R8 idle bits no result", PW'(vcnt - base), PW'(0));
        chk(out_payload == held, "R8 idle bits payload held", out_payload, held);
    endtask

    task automatic t_gaps_excess();
        logic [PW-1:0] p = 80'hDEAD_BEEF_0123_4567_89AB;
        encode(p, 1'b0);
        send(150, 2);
        wait_result(p, 1'b1, "R8 gaps and surplus");
        repeat (300) @(negedge clk);
        chk(vcnt >= 1 && out_valid == 1'b0, "R8 no second result",
            PW'(out_valid), PW'(0));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_clean('0, "zeros");
        t_clean('1, "ones");
        t_clean(80'hAAAA_AAAA_AAAA_AAAA_AAAA, "alternating");
        t_clean(80'h8000_0000_0000_0000_0001, "edge bits");
        t_errors();
        t_bad_crc();
        t_abort();
        t_ignore();
        t_gaps_excess();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule